// File: doc/BRIEF.md
# STN Frame-Rate-Control Dither Engine

This block decides, pixel by pixel, whether a passive-matrix panel element is driven on or off in the current frame. Each pixel arrives with a 4-bit gray level and its column number. The block turns the gray level into a time-averaged brightness: over a run of frames, the pixel is on for a fraction of them that matches its level. Levels 0 and 15 are fixed off and fixed on. Every level in between owns a programmable on/off sequence, and a frame counter steps through that sequence.

The column number is added to the frame count before the sequence is indexed. Two neighbouring pixels at the same level therefore read different positions of the sequence, and the positions they read move on every frame. This spreads the switching of adjacent pixels over time and reduces visible flicker. New sequences are written into a holding register at any time and are copied into use only at a frame start, so a frame never mixes two patterns.

Top module: `dither_engine`

## Requirements
- R1: While `rst` is high, and in the cycle after it is sampled high, `out_valid` and `out_on` are 0.
- R2: A valid pixel with gray level 15 gives `out_on` = 1 in every frame and at every column.
- R3: A valid pixel with gray level 0 gives `out_on` = 0 in every frame and at every column. A pattern write with `pat_sel` equal to 0 or 15 changes no output.
- R4: A pixel presented with `pix_valid` high at clock edge t shows up as `out_valid` = 1 after edge t, together with its `out_on`. For gray level g in 1..14, `out_on` is bit ((f + x) mod N) of the pattern in use for level g. Here x is `pix_col`, f is the number of frame-start strobes since reset, and N is the pattern length of g. Bit 0 is the least significant bit of the pattern.
- R5: Pattern length N and on-count k per gray level (level:N/k): 1:7/1, 2:5/1, 3:4/1, 4:3/1, 5:5/2, 6:7/3, 7:2/1, 8:7/4, 9:5/3, 10:3/2, 11:7/5, 12:4/3, 13:5/4, 14:7/6.
- R6: Each level has its own frame counter. The counter advances by one on each `frame_start` edge and wraps from N-1 to 0. A pixel presented in the same cycle as `frame_start` uses the count from before the strobe.
- R7: A pattern written with `pat_wr` (level in `pat_sel`, bits in `pat_data[N-1:0]`) has no effect on output until the next `frame_start`. A pixel in the cycle of that strobe still uses the previous pattern. From the following cycle on, the new pattern is used.
- R8: After reset, the pattern of level g has bit i (i < N) set exactly when floor((i+1)k/N) differs from floor(ik/N). Over any N consecutive frames at a fixed column, the pixel is on in exactly k of them.
- R9: A cycle with `pix_valid` low gives `out_valid` = 0 and `out_on` = 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle strobe at the start of each frame |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_gray | input | 4 | Gray level of the pixel |
| pix_col | input | COL_W | Horizontal coordinate of the pixel |
| pat_wr | input | 1 | Pattern write strobe |
| pat_sel | input | 4 | Gray level whose pattern is written |
| pat_data | input | 7 | New pattern bits, LSB is position 0 |
| out_valid | output | 1 | Drive decision present |
| out_on | output | 1 | Pixel on in this frame |

## Verification
A level counter that drifts, or one that wraps at the wrong length, shifts that level's on/off sequence. The error shows on the first pixel of that level after the next frame strobe. A pattern copied into use at the wrong time shows up as a changed decision before the strobe that should have applied it. Sweeping every level over many columns and more than seven frames catches either fault within a few frames. A wrong modulo of the column flips neighbouring columns within the first frame.

// File: rtl/dither_pkg.sv
package dither_pkg;

    localparam int GRAY_W  = 4;
    localparam int LVL_CNT = 1 << GRAY_W;
    localparam int PAT_W   = 7;
    localparam int CNT_W   = 3;

    typedef struct packed {
        logic              valid;
        logic [GRAY_W-1:0] gray;
    } pix_req_t;

    typedef struct packed {
        logic valid;
        logic on;
    } pix_drive_t;

    // Sequence length per gray level.
    function automatic int lvl_len(input int g);
        case (g)
            1, 6, 8, 11, 14: return 7;
            2, 5, 9, 13:     return 5;
            3, 12:           return 4;
            4, 10:           return 3;
            7:               return 2;
            default:         return 1;
        endcase
    endfunction

    // On-count per sequence for each gray level.
    function automatic int lvl_num(input int g);
        case (g)
            1, 2, 3, 4, 7: return 1;
            5, 10:         return 2;
            6, 9, 12:      return 3;
            8, 13:         return 4;
            11:            return 5;
            14:            return 6;
            15:            return 1;
            default:       return 0;
        endcase
    endfunction

    // Evenly spread default sequence with lvl_num ones in lvl_len bits.
    function automatic logic [PAT_W-1:0] lvl_default(input int g);
        logic [PAT_W-1:0] p;
        int n;
        int k;
        p = '0;
        n = lvl_len(g);
        k = lvl_num(g);
        for (int i = 0; i < PAT_W; i++) begin
            if (i < n && (((i + 1) * k) / n) != ((i * k) / n)) begin
                p[i] = 1'b1;
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/dither_lane.sv
module dither_lane
    import dither_pkg::*;
#(
    parameter int LVL   = 1,
    parameter int COL_W = 11,
    parameter int N     = lvl_len(LVL)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    input  logic             wr_en,
    input  logic [N-1:0]     wr_data,
    input  logic [COL_W-1:0] col,
    output logic             on_bit
);

    localparam logic [PAT_W-1:0] DEF_FULL = lvl_default(LVL);
    localparam logic [N-1:0]     DEF      = DEF_FULL[N-1:0];
    localparam logic [CNT_W-1:0] LAST     = CNT_W'(N - 1);
    localparam logic [COL_W:0]   LEN_W    = (COL_W + 1)'(N);

    logic [N-1:0]     shadow_q;
    logic [N-1:0]     active_q;
    logic [CNT_W-1:0] phase_q;
    logic [COL_W:0]   sum_w;
    logic [COL_W:0]   rem_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= DEF;
            active_q <= DEF;
            phase_q  <= '0;
        end else begin
            if (wr_en) begin
                shadow_q <= wr_data;
            end
            if (frame_start) begin
                active_q <= shadow_q;
                phase_q  <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
            end
        end
    end

    assign sum_w = {1'b0, col} + {{(COL_W + 1 - CNT_W){1'b0}}, phase_q};
    assign rem_w = sum_w % LEN_W;

    always_comb begin
        on_bit = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (rem_w == (COL_W + 1)'(i)) begin
                on_bit = active_q[i];
            end
        end
    end

endmodule

// File: rtl/dither_out.sv
module dither_out
    import dither_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  pix_req_t           req,
    input  logic [LVL_CNT-1:0] lane_bits,
    output pix_drive_t         drv
);

    always_ff @(posedge clk) begin
        if (rst) begin
            drv <= '0;
        end else begin
            drv.valid <= req.valid;
            drv.on    <= req.valid & lane_bits[req.gray];
        end
    end

endmodule

// File: rtl/dither_engine.sv
module dither_engine
    import dither_pkg::*;
#(
    parameter int COL_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    input  logic             pix_valid,
    input  logic [3:0]       pix_gray,
    input  logic [COL_W-1:0] pix_col,
    input  logic             pat_wr,
    input  logic [3:0]       pat_sel,
    input  logic [6:0]       pat_data,
    output logic             out_valid,
    output logic             out_on
);

    logic [LVL_CNT-1:0] lane_bits;
    pix_req_t           req;
    pix_drive_t         drv;

    assign lane_bits[0]         = 1'b0;
    assign lane_bits[LVL_CNT-1] = 1'b1;

    for (genvar g = 1; g < LVL_CNT - 1; g++) begin : g_lane
        localparam int LEN = lvl_len(g);
        logic wr_hit;
        assign wr_hit = pat_wr && (pat_sel == GRAY_W'(g));

        dither_lane #(
            .LVL   (g),
            .COL_W (COL_W),
            .N     (LEN)
        ) u_lane (
            .clk         (clk),
            .rst         (rst),
            .frame_start (frame_start),
            .wr_en       (wr_hit),
            .wr_data     (pat_data[LEN-1:0]),
            .col         (pix_col),
            .on_bit      (lane_bits[g])
        );
    end

    assign req.valid = pix_valid;
    assign req.gray  = pix_gray;

    dither_out u_out (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .lane_bits (lane_bits),
        .drv       (drv)
    );

    assign out_valid = drv.valid;
    assign out_on    = drv.on;

endmodule

// File: rtl/dither_engine_chk.sv
module dither_engine_chk (
    input logic       clk,
    input logic       rst,
    input logic       pix_valid,
    input logic [3:0] pix_gray,
    input logic       out_valid,
    input logic       out_on
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_on));

    a_r2_full_on: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && pix_gray == 4'hF) |=> (out_valid && out_on));

    a_r3_zero_off: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && pix_gray == 4'h0) |=> (out_valid && !out_on));

    a_r4_valid_follow: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> out_valid);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |=> (!out_valid && !out_on));

endmodule

bind dither_engine dither_engine_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pix_valid (pix_valid),
    .pix_gray  (pix_gray),
    .out_valid (out_valid),
    .out_on    (out_on)
);

// File: tb/dither_engine_bench.sv
module dither_engine_bench;

    localparam int COL_W = 11;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             frame_start = 1'b0;
    logic             pix_valid = 1'b0;
    logic [3:0]       pix_gray = '0;
    logic [COL_W-1:0] pix_col = '0;
    logic             pat_wr = 1'b0;
    logic [3:0]       pat_sel = '0;
    logic [6:0]       pat_data = '0;
    logic             out_valid;
    logic             out_on;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int model_f;
    int shadow_m [16];
    int active_m [16];
    int acc [16];

    always #5 clk = ~clk;

    dither_engine #(.COL_W(COL_W)) u_dither_engine (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .pix_valid   (pix_valid),
        .pix_gray    (pix_gray),
        .pix_col     (pix_col),
        .pat_wr      (pat_wr),
        .pat_sel     (pat_sel),
        .pat_data    (pat_data),
        .out_valid   (out_valid),
        .out_on      (out_on)
    );

    function automatic int len_of(input int g);
        case (g)
            1, 6, 8, 11, 14: return 7;
            2, 5, 9, 13:     return 5;
            3, 12:           return 4;
            4, 10:           return 3;
            7:               return 2;
            default:         return 1;
        endcase
    endfunction

    function automatic int num_of(input int g);
        case (g)
            1, 2, 3, 4, 7: return 1;
            5, 10:         return 2;
            6, 9, 12:      return 3;
            8, 13:         return 4;
            11:            return 5;
            14:            return 6;
            default:       return 0;
        endcase
    endfunction

    function automatic int def_pat(input int g);
        int n = len_of(g);
        int k = num_of(g);
        int p = 0;
        for (int i = 0; i < n; i++)
            if (((i + 1) * k) / n != (i * k) / n) p = p | (1 << i);
        return p;
    endfunction

    function automatic int expect_on(input int g, input int x);
        int n;
        if (g == 0) return 0;
        if (g == 15) return 1;
        n = len_of(g);
        return (active_m[g] >> ((model_f + x) % n)) & 1;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pixel(input string req, input int g, input int x, input bit with_fs);
        int e;
        e = expect_on(g, x);
        pix_valid   = 1'b1;
        pix_gray    = 4'(g);
        pix_col     = COL_W'(x);
        frame_start = with_fs;
        @(negedge clk);
        pix_valid   = 1'b0;
        frame_start = 1'b0;
        if (with_fs) begin
            for (int i = 1; i < 15; i++) active_m[i] = shadow_m[i];
            model_f++;
        end
        chk(req, int'(out_valid), 1);
        chk(req, int'(out_on), e);
    endtask

    task automatic frame_strobe();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        for (int i = 1; i < 15; i++) active_m[i] = shadow_m[i];
        model_f++;
    endtask

    task automatic write_pat(input int sel, input int data);
        pat_wr   = 1'b1;
        pat_sel  = 4'(sel);
        pat_data = 7'(data);
        @(negedge clk);
        pat_wr = 1'b0;
        if (sel >= 1 && sel <= 14)
            shadow_m[sel] = data & ((1 << len_of(sel)) - 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model_f = 0;
        for (int i = 0; i < 16; i++) begin
            shadow_m[i] = def_pat(i);
            active_m[i] = def_pat(i);
            acc[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        chk("R1 valid", int'(out_valid), 0);
        chk("R1 on", int'(out_on), 0);
        rst = 1'b0;
        @(negedge clk);
        // R9: idle cycle gives no drive
        chk("R9 valid", int'(out_valid), 0);
        chk("R9 on", int'(out_on), 0);

        // R4 R5 R6 R8 sweep with reset patterns
        for (int fr = 0; fr < 24; fr++) begin
            for (int g = 0; g < 16; g++) begin
                for (int ci = 0; ci < 11; ci++) begin
                    int x;
                    x = (ci < 9) ? ci : ((ci == 9) ? 2047 : 1000);
                    if (g == 15) pixel("R2", g, x, 1'b0);
                    else if (g == 0) pixel("R3", g, x, 1'b0);
                    else pixel("R4 R5 R6", g, x, 1'b0);
                    if (ci == 0 && fr < len_of(g)) acc[g] += int'(out_on);
                end
            end
            frame_strobe();
        end
        // R8: on-count over one sequence length
        for (int g = 1; g < 15; g++) chk("R8 count", acc[g], num_of(g));

        // R9 again mid-run
        @(negedge clk);
        chk("R9 valid", int'(out_valid), 0);
        chk("R9 on", int'(out_on), 0);

        // R7: write does not act before the strobe
        write_pat(14, 7'b0000001);
        write_pat(7, 2'b10);
        write_pat(3, 4'b0110);
        for (int x = 0; x < 8; x++) pixel("R7 before", 14, x, 1'b0);
        for (int x = 0; x < 4; x++) pixel("R7 before", 7, x, 1'b0);
        // R6 R7: pixel in the strobe cycle uses old count and old pattern
        pixel("R6 R7 same-cycle", 14, 3, 1'b1);
        pixel("R6 R7 same-cycle", 3, 1, 1'b0);
        for (int fr = 0; fr < 9; fr++) begin
            for (int g = 1; g < 15; g++)
                for (int x = 0; x < 8; x++) pixel("R7 after", g, x, 1'b0);
            frame_strobe();
        end

        // R3: writes to fixed levels have no effect
        write_pat(0, 7'h7F);
        write_pat(15, 7'h00);
        frame_strobe();
        for (int x = 0; x < 12; x++) begin
            pixel("R3 level0", 0, x, 1'b0);
            pixel("R3 level15", 15, x, 1'b0);
        end

        // R1: reset restores defaults and counters
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 valid", int'(out_valid), 0);
        chk("R1 on", int'(out_on), 0);
        rst = 1'b0;
        model_f = 0;
        for (int i = 0; i < 16; i++) begin
            shadow_m[i] = def_pat(i);
            active_m[i] = def_pat(i);
        end
        for (int g = 1; g < 15; g++)
            for (int x = 0; x < 8; x++) pixel("R1 R8 defaults", g, x, 1'b0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule